// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit-Set Execution Unit

This unit executes the second byte of a prefixed byte-manipulation instruction. It takes the opcode byte, the 8-bit operand already fetched from a register or from memory, and the current carry. It returns the new value, the new carry, and the register code the value goes back to. It also reports whether the operand lives in memory and how many clock cycles the instruction form costs.

The opcode byte has three fields. Bits 7:6 hold the group. Bits 5:3 hold either the shift kind or the bit index. Bits 2:0 hold the register code. Group 00 covers eight shift and rotate kinds, one of which is an unused hole. Group 11 forces one bit of the operand to one. Groups 01 and 10 are not executed here. The prefix fetch, the register file and the indexed address arithmetic belong to the surrounding core. The core drives `idx_form` when the instruction came through an indexed prefix.

Each request is accepted on a clock where `in_valid` is high. Its result appears on the registered outputs one clock later, together with a one-cycle `out_valid` pulse.

Top module: `prefix_shift_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result`, `carry_out`, `dest_reg`, `mem_operand`, `unsupported` and `cycle_count` all become zero.
- R2: A request sampled with `in_valid` high produces `out_valid` high on the following cycle. When `in_valid` was low, `out_valid` is low and every other output keeps its previous value.
- R3: The group is decoded from `opcode[7:6]`, the kind or bit index from `opcode[5:3]`, and the register code from `opcode[2:0]`. `dest_reg` repeats the register code. `mem_operand` is 1 when the code is 110 or when `idx_form` is 1.
- R4: The circular rotates are group 00 with kind 000 and kind 001. Kind 000 rotates left: bit 7 goes to both bit 0 and `carry_out`. Kind 001 rotates right: bit 0 goes to both bit 7 and `carry_out`.
- R5: The rotates through carry are group 00 with kind 010 and kind 011. Kind 010 shifts left, with `carry_in` entering bit 0 and bit 7 leaving to `carry_out`. Kind 011 shifts right, with `carry_in` entering bit 7 and bit 0 leaving to `carry_out`.
- R6: Group 00 kind 100 shifts left with 0 entering bit 0 and bit 7 leaving to `carry_out`.
- R7: Group 00 kind 101 shifts right and keeps bit 7. Kind 111 shifts right with 0 entering bit 7. In both kinds bit 0 leaves to `carry_out`.
- R8: Group 11 sets bit b of the operand, where b is `opcode[5:3]` and bit 0 is the least significant bit. `carry_out` equals `carry_in`. For example, DAh sets bit 3 with register code 010, and EEh sets bit 5 of the memory operand.
- R9: Group 00 with kind 110, group 01 and group 10 set `unsupported`. In these cases `result` equals the operand and `carry_out` equals `carry_in`.
- R10: `cycle_count` is 8 for a register operand, 15 for a memory operand without `idx_form`, and 23 whenever `idx_form` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Second instruction byte |
| operand | input | 8 | Operand value from a register or memory |
| carry_in | input | 1 | Current carry flag |
| idx_form | input | 1 | Instruction arrived through an indexed prefix |
| out_valid | output | 1 | Result registered from the previous request |
| result | output | 8 | New operand value |
| carry_out | output | 1 | New carry flag |
| dest_reg | output | 3 | Register code for write-back |
| mem_operand | output | 1 | Operand lives in memory |
| unsupported | output | 1 | Opcode not executed by this unit |
| cycle_count | output | 5 | Clock cycles for this instruction form |

## Verification
The hardest behaviour to observe from the ports is the role of the incoming carry. It reaches the result only in the two through-carry kinds. It passes unchanged in the bit-set group and in the unsupported cases, and every other kind must ignore it. A second difficult case is an indexed form whose register field is not 110, which must still be treated as memory.

To reach these cases, the stimulus sweeps all 256 opcode values with both carry levels and both `idx_form` levels. Each sweep uses a different operand pattern. Idle cycles are inserted between bursts so that holding of the outputs is also observed.

// File: rtl/pshift_pkg.sv
// Shared types for the prefixed rotate/shift/bit-set unit.
// Assumes an opcode byte split as group[7:6], field[5:3], register[2:0].
package pshift_pkg;

    localparam int OPC_W = 8;
    localparam int FLD_W = 3;
    localparam logic [FLD_W-1:0] MEM_CODE = 3'b110;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLEAR = 2'b10,
        GRP_SETB  = 2'b11
    } grp_e;

    typedef enum logic [FLD_W-1:0] {
        SH_ROL_CIRC = 3'b000,
        SH_ROR_CIRC = 3'b001,
        SH_ROL_CY   = 3'b010,
        SH_ROR_CY   = 3'b011,
        SH_SHL_ZERO = 3'b100,
        SH_SHR_SIGN = 3'b101,
        SH_HOLE     = 3'b110,
        SH_SHR_ZERO = 3'b111
    } shop_e;

    typedef struct packed {
        grp_e             grp;
        logic [FLD_W-1:0] fld;
        logic [FLD_W-1:0] dst;
        logic             mem;
        logic             unsup;
    } dec_t;

endpackage

// File: rtl/pshift_decode.sv
// Opcode field splitter and timing classifier.
// Does: breaks the opcode into group, field and register code, flags memory
// operands and unsupported encodings, and picks the cycle count.
// Assumes: an indexed form always addresses memory, whatever its register code.
module pshift_decode
    import pshift_pkg::*;
#(
    parameter int CYC_W   = 5,
    parameter int CYC_REG = 8,
    parameter int CYC_MEM = 15,
    parameter int CYC_IDX = 23
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             idx_form,
    output dec_t             dec,
    output logic [CYC_W-1:0] cycles
);

    // Field split and classification of the opcode byte.
    always_comb begin
        dec.grp   = grp_e'(opcode[7:6]);
        dec.fld   = opcode[5:3];
        dec.dst   = opcode[2:0];
        dec.mem   = (opcode[2:0] == MEM_CODE) || idx_form;
        dec.unsup = (dec.grp == GRP_TEST) || (dec.grp == GRP_CLEAR) ||
                    ((dec.grp == GRP_SHIFT) && (shop_e'(dec.fld) == SH_HOLE));
    end

    // Cycle count by operand location.
    always_comb begin
        if (idx_form)     cycles = CYC_W'(CYC_IDX);
        else if (dec.mem) cycles = CYC_W'(CYC_MEM);
        else              cycles = CYC_W'(CYC_REG);
    end

endmodule

// File: rtl/pshift_shifter.sv
// Rotate and shift datapath for group 00.
// Does: one of eight shift kinds on a DATA_W-bit operand with carry in and out.
// Assumes: the hole kind passes the operand and the carry through untouched.
module pshift_shifter
    import pshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shop_e             kind,
    input  logic [DATA_W-1:0] x,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int MSB = DATA_W - 1;

    // Shift kind selection.
    always_comb begin
        res  = x;
        cout = cin;
        unique case (kind)
            SH_ROL_CIRC: begin res = {x[MSB-1:0], x[MSB]}; cout = x[MSB]; end
            SH_ROR_CIRC: begin res = {x[0], x[MSB:1]};     cout = x[0];   end
            SH_ROL_CY:   begin res = {x[MSB-1:0], cin};    cout = x[MSB]; end
            SH_ROR_CY:   begin res = {cin, x[MSB:1]};      cout = x[0];   end
            SH_SHL_ZERO: begin res = {x[MSB-1:0], 1'b0};   cout = x[MSB]; end
            SH_SHR_SIGN: begin res = {x[MSB], x[MSB:1]};   cout = x[0];   end
            SH_SHR_ZERO: begin res = {1'b0, x[MSB:1]};     cout = x[0];   end
            default:     begin res = x;                    cout = cin;    end
        endcase
    end

    // Circular rotates keep the population count of the operand.
    always_comb begin
        if (kind == SH_ROL_CIRC || kind == SH_ROR_CIRC)
            AST_ROT_POPCOUNT: assert ($countones(res) == $countones(x)); // R4
    end

endmodule

// File: rtl/pshift_bitset.sv
// Bit-set datapath for group 11.
// Does: forces bit idx of the operand to one, one lane per bit.
// Assumes: idx is narrower than or equal to the index width of DATA_W.
module pshift_bitset #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] x,
    output logic [DATA_W-1:0] res
);

    // One OR lane per operand bit.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign res[i] = x[i] | (idx == IDX_W'(i));
    end

    // At most one bit changes, and it can only change from zero to one.
    always_comb begin
        AST_SET_SINGLE: assert ($onehot0(res ^ x) && ((res & x) == x)); // R8
    end

endmodule

// File: rtl/prefix_shift_unit.sv
// Prefixed rotate/shift/bit-set execution unit (top).
// Does: decodes the opcode byte, runs the shifter or the bit-set lane, and
// registers the result with a one-cycle valid pulse.
// Assumes: the operand is already fetched and write-back is done by the core.
module prefix_shift_unit
    import pshift_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CYC_W   = 5,
    parameter int CYC_REG = 8,
    parameter int CYC_MEM = 15,
    parameter int CYC_IDX = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic              idx_form,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic [FLD_W-1:0]  dest_reg,
    output logic              mem_operand,
    output logic              unsupported,
    output logic [CYC_W-1:0]  cycle_count
);

    dec_t              dec;
    logic [CYC_W-1:0]  cyc_n;
    logic [DATA_W-1:0] sh_res, set_res, res_n;
    logic              sh_cy, cy_n;

    pshift_decode #(
        .CYC_W(CYC_W), .CYC_REG(CYC_REG), .CYC_MEM(CYC_MEM), .CYC_IDX(CYC_IDX)
    ) u_dec (
        .opcode(opcode), .idx_form(idx_form), .dec(dec), .cycles(cyc_n)
    );

    pshift_shifter #(.DATA_W(DATA_W)) u_sh (
        .kind(shop_e'(dec.fld)), .x(operand), .cin(carry_in),
        .res(sh_res), .cout(sh_cy)
    );

    pshift_bitset #(.DATA_W(DATA_W), .IDX_W(FLD_W)) u_set (
        .idx(dec.fld), .x(operand), .res(set_res)
    );

    // Selects the datapath result by group.
    always_comb begin
        unique case (dec.grp)
            GRP_SHIFT: begin res_n = sh_res;  cy_n = sh_cy;    end
            GRP_SETB:  begin res_n = set_res; cy_n = carry_in; end
            default:   begin res_n = operand; cy_n = carry_in; end
        endcase
    end

    // Output register: captures on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            carry_out   <= 1'b0;
            dest_reg    <= '0;
            mem_operand <= 1'b0;
            unsupported <= 1'b0;
            cycle_count <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= res_n;
                carry_out   <= cy_n;
                dest_reg    <= dec.dst;
                mem_operand <= dec.mem;
                unsupported <= dec.unsup;
                cycle_count <= cyc_n;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_UNSUP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unsupported) |->
        (result == $past(operand) && carry_out == $past(carry_in))); // R9
    AST_SET_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[7:6]) == 2'b11) |->
        (carry_out == $past(carry_in))); // R8
    AST_REG_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mem_operand) |-> (cycle_count == CYC_W'(CYC_REG))); // R10

endmodule

// File: tb/prefix_shift_unit_tb.sv
// Bench: behavioural reference model compared on every clock.
module prefix_shift_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [7:0] operand = 8'h00;
    logic       carry_in = 1'b0;
    logic       idx_form = 1'b0;
    logic       out_valid, carry_out, mem_operand, unsupported;
    logic [7:0] result;
    logic [2:0] dest_reg;
    logic [4:0] cycle_count;

    int n_checks = 0;
    int n_fail = 0;
    int e_valid = 0, e_res = 0, e_cy = 0, e_dst = 0, e_mem = 0, e_uns = 0, e_cyc = 0;
    string e_tag = "R1";
    bit in_reset = 1'b1;

    always #4 clk = ~clk;

    prefix_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .carry_in(carry_in), .idx_form(idx_form),
        .out_valid(out_valid), .result(result), .carry_out(carry_out),
        .dest_reg(dest_reg), .mem_operand(mem_operand),
        .unsupported(unsupported), .cycle_count(cycle_count)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (opcode %0h)", req, what, act, exp, opcode);
        end
    endtask

    // Compare the outputs against the model's expectation for this cycle.
    task automatic compare();
        string vtag;
        string rtag;
        vtag = in_reset ? "R1" : "R2";
        rtag = in_reset ? "R1" : e_tag;
        chk(vtag, int'(out_valid), e_valid, "out_valid");
        chk(rtag, int'(result), e_res, "result");
        chk(rtag, int'(carry_out), e_cy, "carry_out");
        chk(in_reset ? "R1" : "R3", int'(dest_reg), e_dst, "dest_reg");
        chk(in_reset ? "R1" : "R3", int'(mem_operand), e_mem, "mem_operand");
        chk(in_reset ? "R1" : "R9", int'(unsupported), e_uns, "unsupported");
        chk(in_reset ? "R1" : "R10", int'(cycle_count), e_cyc, "cycle_count");
    endtask

    // Reference model: expected outputs after the coming edge.
    task automatic model(input bit v, input int op, input int x, input int c, input int ix);
        int g, f, r;
        e_valid = v;
        if (!v) return;
        g = op / 64;
        f = (op / 8) % 8;
        r = op % 8;
        e_dst = r;
        e_mem = (r == 6 || ix != 0) ? 1 : 0;
        e_cyc = (ix != 0) ? 23 : (r == 6 ? 15 : 8);
        e_uns = 0;
        e_res = x;
        e_cy = c;
        if (g == 3) begin
            e_res = x | (1 << f);
            e_tag = "R8";
        end else if (g != 0 || f == 6) begin
            e_uns = 1;
            e_tag = "R9";
        end else begin
            case (f)
                0: begin e_res = (x * 2) % 256 + x / 128; e_cy = x / 128; e_tag = "R4"; end
                1: begin e_res = x / 2 + (x % 2) * 128; e_cy = x % 2; e_tag = "R4"; end
                2: begin e_res = (x * 2) % 256 + c; e_cy = x / 128; e_tag = "R5"; end
                3: begin e_res = x / 2 + c * 128; e_cy = x % 2; e_tag = "R5"; end
                4: begin e_res = (x * 2) % 256; e_cy = x / 128; e_tag = "R6"; end
                5: begin e_res = x / 2 + (x / 128) * 128; e_cy = x % 2; e_tag = "R7"; end
                default: begin e_res = x / 2; e_cy = x % 2; e_tag = "R7"; end
            endcase
        end
    endtask

    task automatic step(input bit v, input int op, input int x, input int c, input int ix);
        @(negedge clk);
        compare();
        in_reset = 1'b0;
        in_valid = v;
        opcode = 8'(op);
        operand = 8'(x);
        carry_in = c[0];
        idx_form = ix[0];
        model(v, op, x, c, ix);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        // R1: reset state observed while reset is held.
        repeat (2) begin @(negedge clk); compare(); end
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        in_reset = 1'b0;
        // R8 examples: DAh (bit 3, code 010) and EEh (bit 5, memory).
        step(1, 8'hDA, 8'h00, 1, 0);
        step(1, 8'hEE, 8'h10, 0, 0);
        step(1, 8'hC6, 8'hFE, 1, 1);
        step(0, 0, 0, 0, 0);          // R2: idle, outputs hold
        step(0, 0, 0, 0, 0);
        // R4..R7 corners with both carry levels.
        for (int k = 0; k < 8; k++) begin
            step(1, k * 8 + 1, 8'h81, 0, 0);
            step(1, k * 8 + 7, 8'h81, 1, 0);
            step(1, k * 8 + 6, 8'h7E, 1, 0);
        end
        step(0, 0, 0, 0, 0);
        // Full sweep: every opcode, both carries, both index levels.
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 256; op++) begin
                step(1, op, (op * 37 + p * 91 + 11) % 256, p % 2, p / 2);
            end
            step(0, 0, 0, 0, 0);
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule